// File: doc/BRIEF.md
# Byte-Link Register Target

This block is the target end of a half-duplex, byte-wide link used to reach registers. A remote initiator sends a request one byte per clock, each byte qualified by a valid strobe, most significant bit first. The top bit of the first byte selects the operation: 1 for a write, 0 for a read. A 15-bit address follows that bit, and a write then carries 32 bits of data. A read request is therefore 2 bytes long and a write request 6 bytes. The block decodes the request and issues a single-cycle read or write strobe on a local register bus. It then waits for that bus to acknowledge.

Once the acknowledge has been captured, the block sends a response back over the same byte lines. A write gets one status byte. A read gets 32 bits of read data, most significant byte first, followed by the status byte. The status byte holds five zero bits, then an acknowledge flag, then a 2-bit status code in bits 1:0.

The initiator owns a direction line. While that line is low the initiator drives the bus. While it is high the target may drive. The target's output enable follows this line in the same cycle, so the initiator can end a transfer by lowering it. If the local bus never answers, an internal timeout produces a response with the acknowledge flag cleared and status zero.

Top module: `bytelink_target`

## Requirements
- R1: A request is taken from bytes with `link_din_vld` high and `link_dir` low. Bit 7 of the first byte is the write flag. The next 15 bits are the address. A write carries 32 data bits after the address and is 6 bytes long; a read is 2 bytes long. Every field is sent most significant bit first.
- R2: Each complete request produces exactly one strobe on the local bus, lasting one cycle: `reg_wr` for a write or `reg_rd` for a read, never both. `reg_addr` and `reg_wdata` hold the decoded fields while the strobe is high.
- R3: `link_oe` equals `link_dir` in the same cycle, with no register in between.
- R4: `link_dout_vld` is never high in a cycle where `link_dir` is low.
- R5: No response byte is marked valid before the local bus acknowledge (or the timeout) has been captured, even when `link_dir` is already high.
- R6: A write response is one byte, `{5'b00000, ack_flag, status[1:0]}`, with the acknowledge flag set to 1 when `reg_ack` was seen.
- R7: A read response is five bytes on consecutive cycles: `reg_rdata[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`, then the status byte as in R6.
- R8: If `reg_ack` has not arrived by the TIMEOUT_CYC-th cycle after the strobe cycle (the strobe cycle counting as the first), the response has the acknowledge flag 0, status 0 and, for a read, all-zero data. An acknowledge in cycle TIMEOUT_CYC or earlier is still honoured.
- R9: If `link_dir` falls before the response is complete, the remaining bytes are dropped. The output enable is released in the same cycle, and the next request is received normally.
- R10: During and right after reset, `reg_wr`, `reg_rd` and `link_dout_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| link_din | input | 8 | Incoming request byte |
| link_din_vld | input | 1 | Qualifies `link_din` |
| link_dir | input | 1 | 0: initiator drives, 1: target may drive |
| link_dout | output | 8 | Outgoing response byte |
| link_dout_vld | output | 1 | Qualifies `link_dout` |
| link_oe | output | 1 | Output enable for the shared byte lines |
| reg_wr | output | 1 | Local bus write strobe, one cycle |
| reg_rd | output | 1 | Local bus read strobe, one cycle |
| reg_addr | output | ADDR_W | Local bus address |
| reg_wdata | output | DATA_W | Local bus write data |
| reg_ack | input | 1 | Local bus acknowledge |
| reg_status | input | STS_W | Local bus status code, taken with `reg_ack` |
| reg_rdata | input | DATA_W | Local bus read data, taken with `reg_ack` |

## Verification
The assertions rely on four assumptions about the inputs:
- the initiator keeps `link_dir` low while it sends request bytes;
- it starts a new request only after the previous response has been collected or abandoned;
- the local bus raises `reg_ack` only for a strobe still outstanding;
- no acknowledge reaches a later transfer.

The bench's initiator keeps to these rules. It raises direction one cycle after the last request byte and lowers it only after the expected byte count or a chosen abort point. Its responder acknowledges only after it has seen a strobe, at a programmed delay. The sweeps walk the address bits, both operations and several acknowledge delays, including the last delay that still counts and the first one that times out.

// File: rtl/bytelink_pkg.sv
`timescale 1ns/1ps
// Shared types for the byte-link register target.
package bytelink_pkg;
    localparam int unsigned LINK_BYTE_W = 8;

    // Transaction phase of the target.
    typedef enum logic [1:0] {
        PH_RECV = 2'd0,
        PH_BUS  = 2'd1,
        PH_SEND = 2'd2
    } phase_t;
endpackage

// File: rtl/bytelink_req_rx.sv
`timescale 1ns/1ps
// Request assembler. Shifts incoming bytes into one frame register and
// ends the frame after the header (read) or header plus data (write),
// depending on the flag bit of the first byte.
// Assumes (1+ADDR_W) and DATA_W are multiples of 8, and that bytes arrive
// only while direction is low.
module bytelink_req_rx #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [7:0]        din,
    input  logic              din_vld,
    input  logic              dir,
    output logic              done,
    output logic              is_wr,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);
    localparam int unsigned HDR_BYTES  = (1 + ADDR_W) / 8;
    localparam int unsigned DATA_BYTES = DATA_W / 8;
    localparam int unsigned TOT_BYTES  = HDR_BYTES + DATA_BYTES;
    localparam int unsigned SH_W       = TOT_BYTES * 8;
    localparam int unsigned CNT_W      = $clog2(TOT_BYTES + 1);

    logic [SH_W-1:0]  sh;
    logic [SH_W-1:0]  sh_next;
    logic [CNT_W-1:0] cnt;
    logic             wr_flag;
    logic             take;
    logic             first;
    logic             flag_now;
    logic             last;

    // Decode of the byte on the bus this cycle.
    always_comb begin
        take     = en && din_vld && !dir;
        sh_next  = {sh[SH_W-9:0], din};
        first    = (cnt == '0);
        flag_now = first ? din[7] : wr_flag;
        last     = take && (flag_now ? (cnt == CNT_W'(TOT_BYTES - 1))
                                     : (cnt == CNT_W'(HDR_BYTES - 1)));
    end

    // Frame assembly and field extraction at the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            cnt     <= '0;
            wr_flag <= 1'b0;
            done    <= 1'b0;
            is_wr   <= 1'b0;
            addr    <= '0;
            wdata   <= '0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                cnt <= '0;
            end else if (take) begin
                sh <= sh_next;
                if (first) begin
                    wr_flag <= din[7];
                end
                if (last) begin
                    cnt   <= '0;
                    done  <= 1'b1;
                    is_wr <= flag_now;
                    if (flag_now) begin
                        addr  <= sh_next[DATA_W +: ADDR_W];
                        wdata <= sh_next[DATA_W-1:0];
                    end else begin
                        addr  <= sh_next[ADDR_W-1:0];
                        wdata <= '0;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // A finished frame always ends on an accepted byte.
    assert_done_after_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(take));
endmodule

// File: rtl/bytelink_bus_ctl.sv
`timescale 1ns/1ps
// Local register bus sequencer. Issues a one-cycle strobe for a decoded
// request, then waits for the acknowledge, up to TIMEOUT_CYC cycles counted
// from the strobe cycle. Captures status and read data, or substitutes a
// no-acknowledge result on timeout.
// Assumes start is not raised while a request is outstanding.
module bytelink_bus_ctl #(
    parameter int unsigned ADDR_W      = 15,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned STS_W       = 2,
    parameter int unsigned TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_wr,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_wdata,
    input  logic              abort,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_ack,
    input  logic [STS_W-1:0]  reg_status,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              done,
    output logic              rsp_ack,
    output logic [STS_W-1:0]  rsp_status,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int unsigned TMO_W = $clog2(TIMEOUT_CYC + 1);

    logic             busy;
    logic [TMO_W-1:0] tmo;
    logic             tmo_hit;

    assign tmo_hit = (tmo == TMO_W'(TIMEOUT_CYC - 1));

    // Strobe issue, acknowledge wait and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            tmo        <= '0;
            reg_wr     <= 1'b0;
            reg_rd     <= 1'b0;
            reg_addr   <= '0;
            reg_wdata  <= '0;
            done       <= 1'b0;
            rsp_ack    <= 1'b0;
            rsp_status <= '0;
            rsp_rdata  <= '0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            done   <= 1'b0;
            if (start) begin
                busy      <= 1'b1;
                tmo       <= '0;
                reg_wr    <= start_wr;
                reg_rd    <= !start_wr;
                reg_addr  <= start_addr;
                reg_wdata <= start_wdata;
            end else if (busy) begin
                if (abort) begin
                    busy <= 1'b0;
                end else if (reg_ack) begin
                    busy       <= 1'b0;
                    done       <= 1'b1;
                    rsp_ack    <= 1'b1;
                    rsp_status <= reg_status;
                    rsp_rdata  <= reg_rdata;
                end else if (tmo_hit) begin
                    busy       <= 1'b0;
                    done       <= 1'b1;
                    rsp_ack    <= 1'b0;
                    rsp_status <= '0;
                    rsp_rdata  <= '0;
                end else begin
                    tmo <= tmo + 1'b1;
                end
            end
        end
    end

    // Strobes last one cycle and never overlap.
    assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) |=> !(reg_wr || reg_rd));
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));
    // Reaching the limit without acknowledge yields a no-ack result.
    assert_timeout_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start && !abort && !reg_ack && tmo_hit) |=> (done && !rsp_ack && rsp_status == '0));
endmodule

// File: rtl/bytelink_rsp_tx.sv
`timescale 1ns/1ps
// Response serializer. Loads the status byte (and read data for a read)
// into a shift register and emits one byte per cycle while direction is
// high. Valid stays low on cycles without a byte. An abort empties it.
// Assumes load is raised only when idle.
module bytelink_rsp_tx
    import bytelink_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned STS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_wr,
    input  logic              ack_bit,
    input  logic [STS_W-1:0]  status,
    input  logic [DATA_W-1:0] rdata,
    input  logic              dir,
    input  logic              abort,
    output logic [7:0]        dout,
    output logic              vld,
    output logic              busy
);
    localparam int unsigned RD_BYTES = DATA_W / LINK_BYTE_W + 1;
    localparam int unsigned SH_W     = RD_BYTES * LINK_BYTE_W;
    localparam int unsigned PAD_W    = LINK_BYTE_W - 1 - STS_W;
    localparam int unsigned CNT_W    = $clog2(RD_BYTES + 1);

    logic [SH_W-1:0]  sh;
    logic [CNT_W-1:0] left;
    logic [7:0]       stat_byte;

    assign stat_byte = {{PAD_W{1'b0}}, ack_bit, status};

    // Load, shift-out and abort of the response bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            left <= '0;
            busy <= 1'b0;
            dout <= '0;
            vld  <= 1'b0;
        end else begin
            if (load) begin
                busy <= 1'b1;
                vld  <= 1'b0;
                if (load_wr) begin
                    sh   <= {stat_byte, {DATA_W{1'b0}}};
                    left <= CNT_W'(1);
                end else begin
                    sh   <= {rdata, stat_byte};
                    left <= CNT_W'(RD_BYTES);
                end
            end else if (busy && abort) begin
                busy <= 1'b0;
                left <= '0;
                vld  <= 1'b0;
            end else if (busy && dir) begin
                dout <= sh[SH_W-1 -: 8];
                sh   <= {sh[SH_W-9:0], 8'h00};
                vld  <= 1'b1;
                left <= left - 1'b1;
                if (left == CNT_W'(1)) begin
                    busy <= 1'b0;
                end
            end else begin
                vld <= 1'b0;
            end
        end
    end

    // A byte is only launched on an edge where direction was high.
    assert_launch_needs_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vld) |-> $past(dir));
    // Bytes are presented one cycle each from a busy serializer.
    assert_byte_from_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> $past(busy));
endmodule

// File: rtl/bytelink_target.sv
`timescale 1ns/1ps
// Byte-link register target. Receives requests over a half-duplex byte
// link, runs them on a local register bus and returns the response while
// the initiator grants the bus via the direction input.
// Assumes the initiator keeps direction low while sending requests and
// starts a new request only after the previous one is finished or dropped.
module bytelink_target
    import bytelink_pkg::*;
#(
    parameter int unsigned ADDR_W      = 15,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned STS_W       = 2,
    parameter int unsigned TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        link_din,
    input  logic              link_din_vld,
    input  logic              link_dir,
    output logic [7:0]        link_dout,
    output logic              link_dout_vld,
    output logic              link_oe,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_ack,
    input  logic [STS_W-1:0]  reg_status,
    input  logic [DATA_W-1:0] reg_rdata
);
    phase_t            phase;
    logic              dir_q;
    logic              dir_fall;
    logic              rx_done;
    logic              rx_wr;
    logic [ADDR_W-1:0] rx_addr;
    logic [DATA_W-1:0] rx_wdata;
    logic              bus_done;
    logic              bus_ack;
    logic [STS_W-1:0]  bus_status;
    logic [DATA_W-1:0] bus_rdata;
    logic [7:0]        tx_byte;
    logic              tx_vld;
    logic              tx_busy;
    logic              tx_load;

    assign dir_fall      = dir_q && !link_dir;
    assign tx_load       = bus_done && (phase == PH_BUS) && !dir_fall;
    assign link_oe       = link_dir;
    assign link_dout     = tx_byte;
    assign link_dout_vld = tx_vld && link_dir;

    // Direction history for detecting a release by the initiator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
        end else begin
            dir_q <= link_dir;
        end
    end

    // Transaction phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_RECV;
        end else begin
            case (phase)
                PH_RECV: if (rx_done) phase <= PH_BUS;
                PH_BUS: begin
                    if (dir_fall)      phase <= PH_RECV;
                    else if (bus_done) phase <= PH_SEND;
                end
                PH_SEND: begin
                    if (dir_fall || !tx_busy) phase <= PH_RECV;
                end
                default: phase <= PH_RECV;
            endcase
        end
    end

    bytelink_req_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (phase == PH_RECV),
        .din     (link_din),
        .din_vld (link_din_vld),
        .dir     (link_dir),
        .done    (rx_done),
        .is_wr   (rx_wr),
        .addr    (rx_addr),
        .wdata   (rx_wdata)
    );

    bytelink_bus_ctl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STS_W(STS_W), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) bus_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (rx_done && (phase == PH_RECV)),
        .start_wr    (rx_wr),
        .start_addr  (rx_addr),
        .start_wdata (rx_wdata),
        .abort       (dir_fall && (phase == PH_BUS)),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_ack     (reg_ack),
        .reg_status  (reg_status),
        .reg_rdata   (reg_rdata),
        .done        (bus_done),
        .rsp_ack     (bus_ack),
        .rsp_status  (bus_status),
        .rsp_rdata   (bus_rdata)
    );

    bytelink_rsp_tx #(.DATA_W(DATA_W), .STS_W(STS_W)) tx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tx_load),
        .load_wr (rx_wr),
        .ack_bit (bus_ack),
        .status  (bus_status),
        .rdata   (bus_rdata),
        .dir     (link_dir),
        .abort   (dir_fall && (phase == PH_SEND)),
        .dout    (tx_byte),
        .vld     (tx_vld),
        .busy    (tx_busy)
    );

    // The serializer starts only after the bus result was captured.
    assert_send_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(bus_done));
    // A direction drop during the response empties the serializer.
    assert_abort_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SEND && dir_fall) |=> (phase == PH_RECV && !tx_busy));
    // No strobe is raised outside the bus phase entry.
    assert_strobe_in_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) |-> (phase == PH_BUS));
endmodule

// File: tb/bytelink_target_tb.sv
`timescale 1ns/1ps
// Self-checking bench: acts as link initiator and as local register bus.
module bytelink_target_tb_top;
    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  link_din = '0;
    logic        link_din_vld = 1'b0;
    logic        link_dir = 1'b0;
    logic [7:0]  link_dout;
    logic        link_dout_vld;
    logic        link_oe;
    logic        reg_wr;
    logic        reg_rd;
    logic [14:0] reg_addr;
    logic [31:0] reg_wdata;
    logic        reg_ack = 1'b0;
    logic [1:0]  reg_status = '0;
    logic [31:0] reg_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // responder state
    int          rsp_delay = 0;
    int          cd = 0;
    bit          pend = 1'b0;
    bit          acked = 1'b0;
    int          strobe_cnt = 0;
    bit          last_wr = 1'b0;
    logic [14:0] last_addr = '0;
    logic [31:0] last_wdata = '0;

    always #2.5 clk = ~clk;

    bytelink_target #(.TIMEOUT_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .link_din(link_din), .link_din_vld(link_din_vld), .link_dir(link_dir),
        .link_dout(link_dout), .link_dout_vld(link_dout_vld), .link_oe(link_oe),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ack(reg_ack), .reg_status(reg_status), .reg_rdata(reg_rdata)
    );

    function automatic logic [31:0] exp_rdata(input logic [14:0] a);
        return {~a[7:0], 1'b1, a, a[7:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Register bus model: acknowledges a strobe after rsp_delay cycles.
    initial begin
        forever begin
            @(negedge clk);
            reg_ack = 1'b0;
            if (reg_wr || reg_rd) begin
                strobe_cnt++;
                last_wr    = reg_wr;
                last_addr  = reg_addr;
                last_wdata = reg_wdata;
                pend       = (rsp_delay >= 0);
                cd         = rsp_delay;
            end
            if (pend) begin
                if (cd == 0) begin
                    reg_ack    = 1'b1;
                    reg_status = last_addr[1:0];
                    reg_rdata  = exp_rdata(last_addr);
                    acked      = 1'b1;
                    pend       = 1'b0;
                end else begin
                    cd--;
                end
            end
        end
    end

    // One full transfer; drop >= 0 lowers direction after that many bytes.
    task automatic do_txn(input bit wr, input logic [14:0] a, input logic [31:0] d,
                          input int dly, input int drop);
        logic [47:0] frame;
        logic [7:0]  eb [5];
        logic [7:0]  gb [8];
        logic [31:0] rd;
        logic [7:0]  sb;
        int          nreq;
        int          nexp;
        int          got;
        int          s0;
        int          late_vld;
        bit          to;
        string       rq;
        frame = {wr, a, d};
        nreq  = wr ? 6 : 2;
        to    = (dly < 0) || (dly >= TMO);
        rd    = to ? 32'h0 : exp_rdata(a);
        sb    = {5'b00000, !to, to ? 2'b00 : a[1:0]};
        rq    = to ? "R8" : (wr ? "R6" : "R7");
        if (wr) begin
            nexp  = 1;
            eb[0] = sb;
        end else begin
            nexp  = 5;
            eb[0] = rd[31:24];
            eb[1] = rd[23:16];
            eb[2] = rd[15:8];
            eb[3] = rd[7:0];
            eb[4] = sb;
        end
        rsp_delay = dly;
        acked     = 1'b0;
        s0        = strobe_cnt;
        for (int i = 0; i < nreq; i++) begin
            @(negedge clk);
            link_din     = frame[47-8*i -: 8];
            link_din_vld = 1'b1;
        end
        @(negedge clk);
        link_din_vld = 1'b0;
        link_din     = '0;
        @(negedge clk);
        link_dir = 1'b1;
        got = 0;
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            chk(link_oe == link_dir, "R3", "oe vs dir", 48'(link_oe), 48'(link_dir));
            if (link_dout_vld) begin
                if (!to) chk(acked, "R5", "byte before ack", 48'(acked), 48'd1);
                if (got < 8) gb[got] = link_dout;
                got++;
            end
            if (drop >= 0 && got >= drop) break;
            if (drop < 0 && got >= nexp) break;
        end
        link_dir = 1'b0;
        #1;
        chk(link_oe == 1'b0, "R9", "oe after dir drop", 48'(link_oe), 48'd0);
        chk(link_dout_vld == 1'b0, "R4", "vld after dir drop", 48'(link_dout_vld), 48'd0);
        late_vld = 0;
        repeat (6) begin
            @(negedge clk);
            if (link_dout_vld) late_vld++;
        end
        chk(late_vld == 0, "R4", "vld with dir low", 48'(late_vld), 48'd0);
        chk(strobe_cnt == s0 + 1, "R2", "strobe count", 48'(strobe_cnt - s0), 48'd1);
        chk(last_wr == wr, "R1", "operation", 48'(last_wr), 48'(wr));
        chk(last_addr == a, "R1", "address", 48'(last_addr), 48'(a));
        if (wr) chk(last_wdata == d, "R1", "write data", 48'(last_wdata), 48'(d));
        if (drop < 0) begin
            chk(got == nexp, rq, "byte count", 48'(got), 48'(nexp));
            for (int i = 0; i < nexp && i < got; i++)
                chk(gb[i] == eb[i], rq, "response byte", 48'(gb[i]), 48'(eb[i]));
        end else begin
            chk(got == drop, "R9", "bytes before abort", 48'(got), 48'(drop));
        end
        repeat (2) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(reg_wr == 1'b0 && reg_rd == 1'b0, "R10", "strobes in reset", 48'({reg_wr, reg_rd}), 48'd0);
        chk(link_dout_vld == 1'b0, "R10", "vld in reset", 48'(link_dout_vld), 48'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(reg_wr == 1'b0 && reg_rd == 1'b0, "R10", "strobes after reset", 48'({reg_wr, reg_rd}), 48'd0);
        chk(link_oe == link_dir, "R3", "oe after reset", 48'(link_oe), 48'(link_dir));
        // R1 R6 R7: walking address bit, both operations, several ack delays
        for (int k = 0; k < 16; k++) begin
            logic [14:0] a;
            logic [31:0] d;
            a = (k == 15) ? 15'h7FFF : (15'd1 << k);
            d = 32'hC0DE_0000 ^ (32'(k) * 32'h0101_0101) ^ {17'h0, a};
            do_txn(1'b1, a, d, k % 4, -1);
            do_txn(1'b0, a, 32'h0, (k + 1) % 5, -1);
        end
        // R8: last delay still honoured, first delay that times out, never
        do_txn(1'b0, 15'h1234, 32'h0, TMO - 1, -1);
        do_txn(1'b1, 15'h0ABC, 32'h8765_4321, TMO - 1, -1);
        do_txn(1'b0, 15'h2222, 32'h0, TMO, -1);
        do_txn(1'b1, 15'h3333, 32'h5555_AAAA, -1, -1);
        do_txn(1'b0, 15'h4444, 32'h0, -1, -1);
        // R5: long wait with direction already high
        do_txn(1'b0, 15'h6001, 32'h0, 9, -1);
        // R9: abort mid-response and before any byte, then recovery
        do_txn(1'b0, 15'h1357, 32'h0, 0, 2);
        do_txn(1'b0, 15'h2468, 32'h0, 1, -1);
        do_txn(1'b0, 15'h0F0F, 32'h0, 0, 0);
        do_txn(1'b1, 15'h7001, 32'hFFFF_0001, 0, -1);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule